// File: doc/BRIEF.md
# Alarm compare and interrupt controller

This block sits beside a calendar counter inside a real-time clock. It holds one alarm byte for each of the eight time fields and compares those bytes with the live counter values on every cycle. When every alarm byte that is not marked "ignore" equals its live field, the block raises an alarm cause. Six rollover strobes from the calendar counter (hundredth, tenth, second, minute, hour, day) are also accepted as periodic causes. Each cause is gated by its own mask bit and latched into a status byte. One interrupt line is driven from that status byte and a global enable.

Software reaches the block through a byte-wide register port with a 5-bit address. Offsets 8 to 15 hold the alarm bytes. Offset 16 is the status/mask register: a write loads the mask, and a read returns the status and then clears it. Offset 17 is the write-only command register. It carries the global interrupt enable, a test-mode flag and a crystal-select code. The test flag and the crystal code are only stored and brought out on ports. They have no effect inside this block.

The alarm detector is a two-state machine. ALM_WAIT means the time does not currently match. ALM_HELD means it does. The transition ALM_WAIT to ALM_HELD is taken when a match appears, and that transition alone produces the alarm cause. The transition ALM_HELD to ALM_WAIT is taken when the match goes away. Both states loop back to themselves otherwise.

Top module: `rtc_alarm_intc`

## Requirements
- R1: A write to offset 8+i (i = 0..7) stores the byte in alarm field i, and a read of that offset returns it unchanged. Field order is i=0 hundredths, 1 hour, 2 minute, 3 second, 4 month, 5 day, 6 year, 7 weekday. Live field i arrives on live_time[8i+7:8i].
- R2: The alarm condition holds when every field whose ignore bit is clear matches its live field. The ignore bit is 0x80 for every field except the hour, whose ignore bit is 0x40. The hour compares bits 7 and 5:0, so 0x80 there is a compared 12-hour flag. All other fields compare bits 6:0.
- R3: The alarm cause (status bit 0) is raised only on the ALM_WAIT to ALM_HELD transition. While the match persists it is not raised again. A new cause needs a mismatch followed by a fresh match.
- R4: Strobe tick_vec[k] (k=0 hundredth, 1 tenth, 2 second, 3 minute, 4 hour, 5 day) is the cause for status bit k+1, i.e. 0x02, 0x04, 0x08, 0x10, 0x20, 0x40.
- R5: A cause is latched only when its mask bit is set in the cycle it occurs. A write to offset 16 loads the mask from data bits 6:0 and leaves the status unchanged.
- R6: A read of offset 16 returns {pending, status[6:0]} on reg_rdata one cycle later, with pending (0x80) set when any status bit is set. The read then clears the status. Causes arriving in the read cycle remain latched. Causes accumulate until read.
- R7: irq is high exactly when some status bit is set and the global enable (command bit 0x10) is set.
- R8: A write to offset 17 stores test mode from bit 0x20 and the crystal code from bits 1:0 (0 = 32.768 kHz, 1 = 1.048576 MHz, 2 = 2.097152 MHz, 3 = 4.194304 MHz) on test_mode and xtal_sel. Reads of offset 17, and of any offset outside 8..16, return 0x00.
- R9: After reset, all alarm bytes, the mask, the status, the command fields, reg_rdata and irq are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd, held until the next read |
| live_time | input | 64 | Live counter fields, field i at bits 8i+7:8i |
| tick_vec | input | 6 | Rollover strobes, hundredth (bit 0) to day (bit 5) |
| irq | output | 1 | Interrupt request, active high |
| xtal_sel | output | 2 | Stored crystal-select code |
| test_mode | output | 1 | Stored test-mode flag |

## Verification
The bench builds the block with its default parameters: eight fields of eight bits, six strobes, the hour at field 1 and the alarm bytes based at offset 8. With these values the register offsets and bit positions named in the requirements can be used as literal values. They also select the hour-specific ignore variant for field 1, so the 0x40 ignore and the compared 0x80 flag can be set against the 0x80 ignore of the other fields. A behavioural model runs next to the design and is compared on every clock. Directed sequences cover matches held for many cycles, ignored fields, causes that pile up, and a read that collides with a new strobe.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    typedef enum logic {
        ALM_WAIT = 1'b0,
        ALM_HELD = 1'b1
    } alm_state_e;

    typedef struct packed {
        logic       test;
        logic       gie;
        logic [1:0] xtal;
    } cmd_fields_t;

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int N_FIELDS   = 8,
    parameter int HOUR_FIELD = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(N_FIELDS)-1:0] idx,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [N_FIELDS*DATA_W-1:0] live_time,
    output logic [DATA_W-1:0]          rd_byte,
    output logic                       alarm_ev
);

    localparam logic [DATA_W-1:0] PLAIN_IGN = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] HOUR_IGN  = DATA_W'(1) << (DATA_W - 2);

    logic [DATA_W-1:0]   alarm_q [N_FIELDS];
    logic [N_FIELDS-1:0] field_ok;
    logic                match;
    alm_state_e          st_q;
    alm_state_e          st_d;

    // alarm byte storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int f = 0; f < N_FIELDS; f++) begin
                alarm_q[f] <= '0;
            end
        end else if (wr_en) begin
            alarm_q[idx] <= wdata;
        end
    end

    assign rd_byte = alarm_q[idx];

    // per-field compare; the hour field uses a different ignore bit
    for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
        localparam logic [DATA_W-1:0] IGN = (i == HOUR_FIELD) ? HOUR_IGN : PLAIN_IGN;
        logic [DATA_W-1:0] lv;
        assign lv          = live_time[i*DATA_W +: DATA_W];
        assign field_ok[i] = (|(alarm_q[i] & IGN)) ||
                             (((alarm_q[i] ^ lv) & ~IGN) == '0);
    end

    assign match = &field_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ALM_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ALM_WAIT: if (match)  st_d = ALM_HELD;
            ALM_HELD: if (!match) st_d = ALM_WAIT;
        endcase
    end

    // outputs: cause only on the WAIT -> HELD transition
    always_comb begin
        alarm_ev = 1'b0;
        unique case (st_q)
            ALM_WAIT: alarm_ev = match;
            ALM_HELD: alarm_ev = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_int_status.sv
module rtc_int_status #(
    parameter int N_CAUSE = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CAUSE-1:0] cause,
    input  logic               mask_wr,
    input  logic [N_CAUSE-1:0] mask_wdata,
    input  logic               clr_rd,
    input  logic               gie,
    output logic [N_CAUSE-1:0] status,
    output logic [N_CAUSE-1:0] mask,
    output logic [N_CAUSE-1:0] set_vec,
    output logic               irq
);

    logic [N_CAUSE-1:0] status_q;
    logic [N_CAUSE-1:0] mask_q;
    logic [N_CAUSE-1:0] status_d;

    assign set_vec  = cause & mask_q;
    assign status_d = (clr_rd ? '0 : status_q) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_d;
            if (mask_wr) begin
                mask_q <= mask_wdata;
            end
        end
    end

    assign status = status_q;
    assign mask   = mask_q;
    assign irq    = (|status_q) & gie;

endmodule

// File: rtl/rtc_cmd_store.sv
module rtc_cmd_store
    import rtc_alarm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int GIE_BIT  = 4,
    parameter int TEST_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              gie,
    output logic              test_mode,
    output logic [1:0]        xtal_sel
);

    cmd_fields_t cmd_q;
    logic        unused_cmd_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_en) begin
            cmd_q.gie  <= wdata[GIE_BIT];
            cmd_q.test <= wdata[TEST_BIT];
            cmd_q.xtal <= wdata[1:0];
        end
    end

    assign unused_cmd_bits = ^{wdata[DATA_W-1:TEST_BIT+1], wdata[GIE_BIT-1:2]};

    assign gie       = cmd_q.gie;
    assign test_mode = cmd_q.test;
    assign xtal_sel  = cmd_q.xtal;

endmodule

// File: rtl/rtc_alarm_intc.sv
module rtc_alarm_intc #(
    parameter int DATA_W     = 8,
    parameter int N_FIELDS   = 8,
    parameter int N_TICKS    = 6,
    parameter int ADDR_W     = 5,
    parameter int HOUR_FIELD = 1,
    parameter int ALARM_BASE = 8,
    parameter int STAT_ADDR  = 16,
    parameter int CMD_ADDR   = 17
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic [N_FIELDS*DATA_W-1:0] live_time,
    input  logic [N_TICKS-1:0]         tick_vec,
    output logic                       irq,
    output logic [1:0]                 xtal_sel,
    output logic                       test_mode
);

    localparam int IDX_W   = $clog2(N_FIELDS);
    localparam int N_CAUSE = N_TICKS + 1;
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(ALARM_BASE);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(ALARM_BASE + N_FIELDS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_ADDR);

    logic               in_alarm;
    logic [IDX_W-1:0]   alm_idx;
    logic [DATA_W-1:0]  alm_byte;
    logic               alarm_ev_w;
    logic               rd_stat_w;
    logic               gie_w;
    logic [N_CAUSE-1:0] stat_w;
    logic [N_CAUSE-1:0] mask_w;
    logic [N_CAUSE-1:0] set_w;

    assign in_alarm  = (reg_addr >= A_LO) && (reg_addr < A_HI);
    assign alm_idx   = IDX_W'(reg_addr - A_LO);
    assign rd_stat_w = reg_rd && (reg_addr == A_STAT);

    rtc_alarm_match #(
        .DATA_W     (DATA_W),
        .N_FIELDS   (N_FIELDS),
        .HOUR_FIELD (HOUR_FIELD)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && in_alarm),
        .idx       (alm_idx),
        .wdata     (reg_wdata),
        .live_time (live_time),
        .rd_byte   (alm_byte),
        .alarm_ev  (alarm_ev_w)
    );

    rtc_int_status #(
        .N_CAUSE (N_CAUSE)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause      ({tick_vec, alarm_ev_w}),
        .mask_wr    (reg_wr && (reg_addr == A_STAT)),
        .mask_wdata (reg_wdata[N_CAUSE-1:0]),
        .clr_rd     (rd_stat_w),
        .gie        (gie_w),
        .status     (stat_w),
        .mask       (mask_w),
        .set_vec    (set_w),
        .irq        (irq)
    );

    rtc_cmd_store #(
        .DATA_W (DATA_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && (reg_addr == A_CMD)),
        .wdata     (reg_wdata),
        .gie       (gie_w),
        .test_mode (test_mode),
        .xtal_sel  (xtal_sel)
    );

    // registered read port; data holds until the next read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (in_alarm) begin
                reg_rdata <= alm_byte;
            end else if (rd_stat_w) begin
                reg_rdata <= {|stat_w, stat_w};
            end else begin
                reg_rdata <= '0;
            end
        end
    end

endmodule

// File: rtl/rtc_alarm_intc_chk.sv
module rtc_alarm_intc_chk #(
    parameter int N_CAUSE = 7,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq,
    input logic               gie,
    input logic [N_CAUSE-1:0] status,
    input logic [N_CAUSE-1:0] mask,
    input logic [N_CAUSE-1:0] set_vec,
    input logic               alarm_ev,
    input logic               rd_stat,
    input logic [DATA_W-1:0]  rdata
);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq);  // R7

    AST_ALARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_ev |=> !alarm_ev);  // R3

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(mask)) == '0));  // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> ((status & ~$past(set_vec)) == '0));  // R6

    AST_PENDING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (rdata[DATA_W-1] == (|$past(status))));  // R6

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stat && (set_vec == '0)) |=> $stable(status));  // R6

endmodule

bind rtc_alarm_intc rtc_alarm_intc_chk #(
    .N_CAUSE (N_TICKS + 1),
    .DATA_W  (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .gie      (gie_w),
    .status   (stat_w),
    .mask     (mask_w),
    .set_vec  (set_w),
    .alarm_ev (alarm_ev_w),
    .rd_stat  (rd_stat_w),
    .rdata    (reg_rdata)
);

// File: tb/rtc_alarm_intc_tb.sv
`timescale 1ns/1ps
module rtc_alarm_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [63:0] live_time = '0;
    logic [5:0]  tick_vec = '0;
    logic        irq;
    logic [1:0]  xtal_sel;
    logic        test_mode;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    rtc_alarm_intc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .live_time (live_time),
        .tick_vec  (tick_vec),
        .irq       (irq),
        .xtal_sel  (xtal_sel),
        .test_mode (test_mode)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_alm [8];
    logic [6:0] m_mask, m_stat;
    logic [1:0] m_xtal;
    logic [7:0] m_rdata;
    bit         m_gie, m_test, m_prev;

    function automatic bit m_match();
        for (int f = 0; f < 8; f++) begin
            logic [7:0] lv;
            int ib;
            lv = live_time[f*8 +: 8];
            ib = (f == 1) ? 6 : 7;
            if (m_alm[f][ib]) continue;
            for (int b = 0; b < 8; b++) begin
                if (b != ib && m_alm[f][b] != lv[b]) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < 8; f++) m_alm[f] = 8'h00;
            m_mask = '0; m_stat = '0; m_xtal = '0; m_rdata = '0;
            m_gie = 0; m_test = 0; m_prev = 0;
        end else begin
            bit mt;
            logic [6:0] ev, nstat;
            mt = m_match();
            ev = {tick_vec, mt && !m_prev};
            m_prev = mt;
            nstat = m_stat;
            if (reg_rd) begin
                if (reg_addr >= 5'd8 && reg_addr <= 5'd15) m_rdata = m_alm[reg_addr - 5'd8];
                else if (reg_addr == 5'd16) begin
                    m_rdata = {(m_stat != 0), m_stat};
                    nstat = '0;
                end else m_rdata = 8'h00;
            end
            nstat = nstat | (ev & m_mask);
            if (reg_wr) begin
                if (reg_addr >= 5'd8 && reg_addr <= 5'd15) m_alm[reg_addr - 5'd8] = reg_wdata;
                else if (reg_addr == 5'd16) m_mask = reg_wdata[6:0];
                else if (reg_addr == 5'd17) begin
                    m_gie = reg_wdata[4]; m_test = reg_wdata[5]; m_xtal = reg_wdata[1:0];
                end
            end
            m_stat = nstat;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            chk("R7 irq vs model", {31'd0, irq}, {31'd0, (m_stat != 0) && m_gie});
            chk("R6 rdata vs model", {24'd0, reg_rdata}, {24'd0, m_rdata});
            chk("R8 xtal vs model", {30'd0, xtal_sel}, {30'd0, m_xtal});
            chk("R8 test vs model", {31'd0, test_mode}, {31'd0, m_test});
        end
    end

    // ---------------- stimulus helpers (entered at negedge) ----------------
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [5:0] tk);
        reg_addr = a; reg_rd = 1'b1; tick_vec = tk;
        @(negedge clk);
        reg_rd = 1'b0; tick_vec = '0;
    endtask

    task automatic pulse(input logic [5:0] tk);
        tick_vec = tk;
        @(negedge clk);
        tick_vec = '0;
    endtask

    task automatic setlive(input logic [63:0] v);
        live_time = v;
        @(negedge clk);
    endtask

    function automatic logic [63:0] pack(input logic [7:0] hs, hr, mi, se, mo, dy, yr, wd);
        return {wd, yr, dy, mo, se, mi, hr, hs};
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    logic [7:0]  av [8];
    logic [63:0] tA;

    initial begin
        av[0] = 8'h11; av[1] = 8'h05; av[2] = 8'h20; av[3] = 8'h30;
        av[4] = 8'h03; av[5] = 8'h0A; av[6] = 8'h12; av[7] = 8'h02;
        tA = pack(av[0], av[1], av[2], av[3], av[4], av[5], av[6], av[7]);

        repeat (3) @(negedge clk);
        chk("R9 irq after reset", {31'd0, irq}, 0);
        chk("R9 rdata after reset", {24'd0, reg_rdata}, 0);
        chk("R9 xtal after reset", {30'd0, xtal_sel}, 0);
        chk("R9 test after reset", {31'd0, test_mode}, 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);

        // command register
        wr(5'd17, 8'h13);
        chk("R8 xtal code 3", {30'd0, xtal_sel}, 3);
        chk("R8 test clear", {31'd0, test_mode}, 0);
        wr(5'd17, 8'h2C);
        chk("R8 test set", {31'd0, test_mode}, 1);
        chk("R8 xtal code 0", {30'd0, xtal_sel}, 0);
        wr(5'd17, 8'h10);

        // alarm bytes
        setlive(tA);
        for (int i = 0; i < 8; i++) wr(5'(8 + i), av[i]);
        for (int i = 0; i < 8; i++) begin
            rd(5'(8 + i), 6'h00);
            chk("R1 alarm readback", {24'd0, reg_rdata}, {24'd0, av[i]});
        end
        wr(5'd16, 8'h01);
        chk("R3 no cause while match persists", {31'd0, irq}, 0);

        // fresh match after mismatch
        setlive(pack(av[0], av[1], 8'h21, av[3], av[4], av[5], av[6], av[7]));
        setlive(tA);
        chk("R2 full match raises irq", {31'd0, irq}, 1);
        repeat (5) @(negedge clk);
        rd(5'd16, 6'h00);
        chk("R6 status read alarm", {24'd0, reg_rdata}, 8'h81);
        chk("R6 irq drops after read", {31'd0, irq}, 0);
        rd(5'd16, 6'h00);
        chk("R3 held match not repeated", {24'd0, reg_rdata}, 8'h00);

        // minute ignored via 0x80
        wr(5'd10, 8'hA0);
        setlive(pack(av[0], av[1], av[2], 8'h31, av[4], av[5], av[6], av[7]));
        setlive(pack(av[0], av[1], 8'h33, av[3], av[4], av[5], av[6], av[7]));
        chk("R2 ignored minute still matches", {31'd0, irq}, 1);
        rd(5'd16, 6'h00);
        chk("R2 ignored minute status", {24'd0, reg_rdata}, 8'h81);

        // hour ignored via 0x40
        wr(5'd9, 8'h45);
        setlive(pack(av[0], av[1], av[2], 8'h31, av[4], av[5], av[6], av[7]));
        setlive(pack(av[0], 8'h07, av[2], av[3], av[4], av[5], av[6], av[7]));
        rd(5'd16, 6'h00);
        chk("R2 hour ignore bit 0x40", {24'd0, reg_rdata}, 8'h81);

        // hour 0x80 is compared, not an ignore bit
        wr(5'd9, 8'h85);
        setlive(pack(av[0], av[1], av[2], 8'h31, av[4], av[5], av[6], av[7]));
        setlive(tA);
        rd(5'd16, 6'h00);
        chk("R2 hour 12h flag compared", {24'd0, reg_rdata}, 8'h00);
        setlive(pack(av[0], 8'h85, av[2], av[3], av[4], av[5], av[6], av[7]));
        rd(5'd16, 6'h00);
        chk("R2 hour 12h flag match", {24'd0, reg_rdata}, 8'h81);

        // periodic causes
        wr(5'd16, 8'h00);
        pulse(6'h3F);
        rd(5'd16, 6'h00);
        chk("R5 masked strobes not latched", {24'd0, reg_rdata}, 8'h00);
        wr(5'd16, 8'h7E);
        pulse(6'h01);
        rd(5'd16, 6'h00);
        chk("R4 hundredth strobe bit", {24'd0, reg_rdata}, 8'h82);
        pulse(6'h24);
        rd(5'd16, 6'h00);
        chk("R4 second and day bits", {24'd0, reg_rdata}, 8'hC8);
        pulse(6'h02);
        pulse(6'h08);
        pulse(6'h10);
        rd(5'd16, 6'h00);
        chk("R6 causes accumulate", {24'd0, reg_rdata}, 8'hB4);

        // read colliding with a new strobe
        pulse(6'h04);
        rd(5'd16, 6'h01);
        chk("R6 read returns old status", {24'd0, reg_rdata}, 8'h88);
        rd(5'd16, 6'h00);
        chk("R6 colliding cause kept", {24'd0, reg_rdata}, 8'h82);

        // enable and mask write
        pulse(6'h04);
        chk("R7 irq with enable", {31'd0, irq}, 1);
        wr(5'd17, 8'h00);
        chk("R7 irq gated by enable", {31'd0, irq}, 0);
        wr(5'd16, 8'h7F);
        wr(5'd17, 8'h10);
        chk("R5 mask write keeps status", {31'd0, irq}, 1);
        rd(5'd17, 6'h00);
        chk("R8 command reads zero", {24'd0, reg_rdata}, 8'h00);
        rd(5'd16, 6'h00);
        chk("R6 status after mask write", {24'd0, reg_rdata}, 8'h88);
        chk("R6 irq cleared", {31'd0, irq}, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule